// File: doc/BRIEF.md
# Power Sequencing Fault and Restart Supervisor

This block decides when the two switching stages of a dual-output power controller may run. It takes digital flags from the analog front end: supply above its turn-on level, reference good, input undervoltage, input overvoltage, bootstrap supply above the main supply, bootstrap supply below its reset level, and two output-feedback over-threshold flags. It also takes an enable pin and a pin that sets the enable pin's polarity. From these it drives two run outputs. The auxiliary run output releases the first stage. The main run output releases the second stage once the bootstrap supply has taken over.

Every flag passes through a synchronizer before use. Ordinary faults and the disable condition drop both run outputs at once. The block then restarts only after the fault is gone and the bootstrap supply has fallen below its reset level. An output-undervoltage timer counts system clock cycles while either feedback flag is raised. If the timer reaches its programmable limit, it latches a harder fault. That fault is released only by an edge on the enable pin or on the undervoltage flag, taken while both feedback flags are clear and the bootstrap supply is below its reset level.

Top module: `pwr_seq_supervisor`

## Requirements
- R1: With `en_pol_i` high, a high `en_pin_i` disables the block. With `en_pol_i` low, a low `en_pin_i` disables it. The disabled state acts as a fault under R2.
- R2: Any of the following drops both run outputs on the third clock edge after the input change: `supply_ok_i` low, `vref_ok_i` low, `vin_uv_i` high, `vin_ov_i` high, or the disable condition.
- R3: While reset is held, both run outputs are low. After reset, `run_aux_o` rises once the supply is on, the reference is good, no fault is present and `boot_reset_i` is high.
- R4: `run_main_o` is high only while `run_aux_o` is high. It rises no earlier than one cycle after `run_aux_o`, and only once the synchronized `boot_above_i` is high.
- R5: After an ordinary fault clears, `run_aux_o` stays low until `boot_reset_i` is high. It then restarts.
- R6: The timer counts each cycle in which either synchronized feedback flag is high. Once it has counted `uvt_limit_i` cycles and a flag is still high, the next edge drops both run outputs and latches a timer fault. With the limit L and a flag raised continuously, `run_aux_o` falls on edge L+3 after the input change.
- R7: The timer clears to zero whenever both feedback flags are low. Separate short pulses therefore never add up to a trip.
- R8: A latched timer fault holds both run outputs low, even when all faults have cleared and `boot_reset_i` is high. It is released by a change of the synchronized `en_pin_i` or `vin_uv_i`, taken while both feedback flags are low and `boot_reset_i` is high. After release, the restart rule of R5 applies.
- R9: An edge on enable or undervoltage does not release a timer fault if it occurs while either feedback flag is high or `boot_reset_i` is low.
- R10: `run_main_o` is requalified on every restart. It stays low after `run_aux_o` returns until `boot_above_i` is seen high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Main supply above turn-on level |
| vref_ok_i | input | 1 | Internal reference within range |
| vin_uv_i | input | 1 | Input voltage below undervoltage level |
| vin_ov_i | input | 1 | Input voltage above overvoltage level |
| boot_above_i | input | 1 | Bootstrap supply above main supply |
| boot_reset_i | input | 1 | Bootstrap supply below its reset level |
| fb_over_a_i | input | 1 | Auxiliary output feedback over threshold |
| fb_over_b_i | input | 1 | Main output feedback over threshold |
| en_pin_i | input | 1 | Enable pin |
| en_pol_i | input | 1 | Enable polarity select |
| uvt_limit_i | input | TMR_W | Timer trip limit in clock cycles |
| run_aux_o | output | 1 | Auxiliary stage run permit |
| run_main_o | output | 1 | Main stage run permit |

## Verification
The hardest state to reach is the latched timer fault, and the conditions under which it may leave that state. The stimulus first keeps a feedback flag high long enough to trip the timer, checking the exact edge on which it trips. It then clears all ordinary faults and checks that the block still stays off. Next it toggles the enable pin twice: once while a feedback flag is high and once while the bootstrap supply is not below its reset level. After each of these toggles the run output must remain low. A final toggle under the proper conditions must restart the block, and a second trip is released through the undervoltage flag. Earlier, three feedback pulses, each just under the limit and separated by short gaps, show that the count does not carry over from one pulse to the next.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

   // synchronized flag bundle; member order fixes the packing of the input vector
   typedef struct packed {
      logic sup;
      logic vref;
      logic uv;
      logic ov;
      logic bgt;
      logic blow;
      logic fba;
      logic fbb;
      logic en;
      logic pol;
   } flags_t;

   localparam int unsigned FLAG_W = $bits(flags_t);

   typedef enum logic [1:0] {
      ST_WAIT = 2'd0,
      ST_RUN  = 2'd1,
      ST_TRIP = 2'd2
   } seq_state_t;

endpackage

// File: rtl/pss_sync_bank.sv
module pss_sync_bank #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   localparam int unsigned LAST = STAGES - 1;

   logic [WIDTH-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("pss_sync_bank: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q_o = stg[LAST];

endmodule

// File: rtl/pss_uv_timer.sv
module pss_uv_timer #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fb_any_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             expired_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             at_limit;

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("pss_uv_timer: CNT_W must be at least 2");
      end
   endgenerate

   assign at_limit = (cnt_q >= limit_i);

   // counts while a flag is raised, saturates at the limit, clears when both drop
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (!fb_any_i) cnt_q <= '0;
      else if (!at_limit) cnt_q <= cnt_q + 1'b1;
   end

   assign expired_o = fb_any_i & at_limit;
   assign cnt_o     = cnt_q;

endmodule

// File: rtl/pss_seq_fsm.sv
module pss_seq_fsm
   import pwr_seq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic fault_i,
   input  logic boot_low_i,
   input  logic boot_gt_i,
   input  logic expired_i,
   input  logic release_i,
   output logic run_aux_o,
   output logic run_main_o
);

   seq_state_t state_q, state_d;
   logic       qual_q, qual_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN: begin
            if (expired_i)    state_d = ST_TRIP;
            else if (fault_i) state_d = ST_WAIT;
         end
         ST_WAIT: begin
            if (expired_i)                   state_d = ST_TRIP;
            else if (!fault_i && boot_low_i) state_d = ST_RUN;
         end
         ST_TRIP: begin
            if (release_i) state_d = ST_WAIT;
         end
         default: state_d = ST_WAIT;
      endcase
   end

   // main permit needs a full cycle of running plus bootstrap takeover; lost on any exit
   always_comb begin
      qual_d = (state_d == ST_RUN) && (state_q == ST_RUN) && (qual_q || boot_gt_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_WAIT;
         qual_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         qual_q  <= qual_d;
      end
   end

   assign run_aux_o  = (state_q == ST_RUN);
   assign run_main_o = qual_q;

endmodule

// File: rtl/pwr_seq_supervisor.sv
module pwr_seq_supervisor
   import pwr_seq_pkg::*;
#(
   parameter int unsigned TMR_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             supply_ok_i,
   input  logic             vref_ok_i,
   input  logic             vin_uv_i,
   input  logic             vin_ov_i,
   input  logic             boot_above_i,
   input  logic             boot_reset_i,
   input  logic             fb_over_a_i,
   input  logic             fb_over_b_i,
   input  logic             en_pin_i,
   input  logic             en_pol_i,
   input  logic [TMR_W-1:0] uvt_limit_i,
   output logic             run_aux_o,
   output logic             run_main_o
);

   logic [FLAG_W-1:0] raw_vec, sync_vec;
   flags_t            flg_s;
   logic              en_d, uv_d;
   logic              disabled, fault_now, fb_any_s, toggle, release_ok;
   logic [TMR_W-1:0]  tmr_cnt;
   logic              tmr_exp;

   assign raw_vec = {supply_ok_i, vref_ok_i, vin_uv_i, vin_ov_i, boot_above_i,
                     boot_reset_i, fb_over_a_i, fb_over_b_i, en_pin_i, en_pol_i};

   pss_sync_bank #(
      .WIDTH  (FLAG_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_vec),
      .q_o   (sync_vec)
   );

   assign flg_s = flags_t'(sync_vec);

   // polarity select: high pol => active-low enable, low pol => active-high enable
   assign disabled  = flg_s.pol ? flg_s.en : ~flg_s.en;
   assign fault_now = ~flg_s.sup | ~flg_s.vref | flg_s.uv | flg_s.ov | disabled;
   assign fb_any_s  = flg_s.fba | flg_s.fbb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_d <= 1'b0;
         uv_d <= 1'b0;
      end else begin
         en_d <= flg_s.en;
         uv_d <= flg_s.uv;
      end
   end

   assign toggle     = (flg_s.en ^ en_d) | (flg_s.uv ^ uv_d);
   assign release_ok = toggle & flg_s.blow & ~fb_any_s;

   pss_uv_timer #(
      .CNT_W (TMR_W)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .fb_any_i  (fb_any_s),
      .limit_i   (uvt_limit_i),
      .cnt_o     (tmr_cnt),
      .expired_o (tmr_exp)
   );

   pss_seq_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .fault_i    (fault_now),
      .boot_low_i (flg_s.blow),
      .boot_gt_i  (flg_s.bgt),
      .expired_i  (tmr_exp),
      .release_i  (release_ok),
      .run_aux_o  (run_aux_o),
      .run_main_o (run_main_o)
   );

endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
   parameter int unsigned CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          run_aux,
   input logic          run_main,
   input logic          fault_now,
   input logic          boot_low_s,
   input logic          bgt_s,
   input logic          fb_any,
   input logic          tmr_expired,
   input logic [CW-1:0] tmr_cnt
);

   assert_fault_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_aux && fault_now) |=> !run_aux);

   assert_start_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_aux) |-> $past(!fault_now));

   assert_main_inside_aux_R4: assert property (@(posedge clk) disable iff (!rst_n)
      run_main |-> run_aux);

   assert_main_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_main) |-> $past(run_aux && bgt_s));

   assert_restart_boot_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_aux) |-> $past(boot_low_s));

   assert_trip_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_expired |=> !run_aux);

   assert_timer_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !fb_any |=> (tmr_cnt == '0));

endmodule

bind pwr_seq_supervisor pss_checker #(.CW(TMR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .run_aux     (run_aux_o),
   .run_main    (run_main_o),
   .fault_now   (fault_now),
   .boot_low_s  (flg_s.blow),
   .bgt_s       (flg_s.bgt),
   .fb_any      (fb_any_s),
   .tmr_expired (tmr_exp),
   .tmr_cnt     (tmr_cnt)
);

// File: tb/sim_pwr_seq_supervisor.sv
`timescale 1ns/1ps
module sim_pwr_seq_supervisor;

   localparam int unsigned TW    = 16;
   localparam int unsigned LIMIT = 8;
   localparam int unsigned NVEC  = 23;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [9:0]    pins = 10'b0000000001;
   logic          run_aux, run_main;
   int            n_chk = 0;
   int            n_bad = 0;
   bit            done = 1'b0;

   always #2.5 clk = ~clk;

   // pins order: {sup, vref, uv, ov, bgt, blow, fba, fbb, en, pol}
   pwr_seq_supervisor #(.TMR_W(TW)) u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .supply_ok_i  (pins[9]),
      .vref_ok_i    (pins[8]),
      .vin_uv_i     (pins[7]),
      .vin_ov_i     (pins[6]),
      .boot_above_i (pins[5]),
      .boot_reset_i (pins[4]),
      .fb_over_a_i  (pins[3]),
      .fb_over_b_i  (pins[2]),
      .en_pin_i     (pins[1]),
      .en_pol_i     (pins[0]),
      .uvt_limit_i  (LIMIT[TW-1:0]),
      .run_aux_o    (run_aux),
      .run_main_o   (run_main)
   );

   // entry: {req[3:0], exp_aux, exp_main, wait[3:0], pins[9:0]}
   localparam logic [19:0] VEC [NVEC] = '{
      {4'd3,  1'b1, 1'b0, 4'd6, 10'b1100010001}, // R3 power-up
      {4'd4,  1'b1, 1'b1, 4'd6, 10'b1100100001}, // R4 bootstrap takeover
      {4'd2,  1'b0, 1'b0, 4'd6, 10'b1110100001}, // R2 input undervoltage
      {4'd5,  1'b0, 1'b0, 4'd6, 10'b1100100001}, // R5 cleared, boot not low
      {4'd10, 1'b1, 1'b0, 4'd6, 10'b1100010001}, // R10 restart, main requalifies
      {4'd4,  1'b1, 1'b1, 4'd6, 10'b1100100001}, // R4
      {4'd1,  1'b0, 1'b0, 4'd6, 10'b1100100011}, // R1 pol high, en high
      {4'd1,  1'b1, 1'b0, 4'd6, 10'b1100010010}, // R1 pol low, en high
      {4'd1,  1'b0, 1'b0, 4'd6, 10'b1100010000}, // R1 pol low, en low
      {4'd5,  1'b1, 1'b0, 4'd6, 10'b1100010010}, // R5
      {4'd2,  1'b0, 1'b0, 4'd6, 10'b1000010010}, // R2 reference bad
      {4'd3,  1'b1, 1'b0, 4'd6, 10'b1100010010}, // R3
      {4'd2,  1'b0, 1'b0, 4'd6, 10'b1101010010}, // R2 overvoltage
      {4'd5,  1'b1, 1'b0, 4'd6, 10'b1100010010}, // R5
      {4'd2,  1'b0, 1'b0, 4'd6, 10'b0100010010}, // R2 supply below turn-on
      {4'd3,  1'b1, 1'b0, 4'd6, 10'b1100010010}, // R3
      {4'd4,  1'b1, 1'b1, 4'd6, 10'b1100100010}, // R4
      {4'd7,  1'b1, 1'b1, 4'd7, 10'b1100101010}, // R7 pulse A below limit
      {4'd7,  1'b1, 1'b1, 4'd4, 10'b1100100010}, // R7 gap
      {4'd7,  1'b1, 1'b1, 4'd7, 10'b1100100110}, // R7 pulse B below limit
      {4'd7,  1'b1, 1'b1, 4'd4, 10'b1100100010}, // R7 gap
      {4'd7,  1'b1, 1'b1, 4'd7, 10'b1100101010}, // R7 pulse A again
      {4'd7,  1'b1, 1'b1, 4'd4, 10'b1100100010}  // R7
   };

   task automatic chk(input int req, input logic a1, input logic a2,
                      input logic e1, input logic e2);
      n_chk++;
      if (a1 !== e1 || a2 !== e2) begin
         n_bad++;
         $display("FAIL R%0d: run_aux/run_main = %b%b, expected %b%b", req, a1, a2, e1, e2);
      end
   endtask

   task automatic step(input logic [9:0] p, input int cyc);
      pins = p;
      repeat (cyc) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk(3, run_aux, run_main, 1'b0, 1'b0); // R3 reset state
      pins = 10'b1100010001;
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         step(VEC[i][9:0], int'(VEC[i][13:10]));
         chk(int'(VEC[i][19:16]), run_aux, run_main, VEC[i][15], VEC[i][14]);
      end

      // R6 exact trip edge: flag raised, trip on edge LIMIT+3
      step(10'b1100101010, LIMIT + 2);
      chk(6, run_aux, run_main, 1'b1, 1'b1);
      @(negedge clk);
      chk(6, run_aux, run_main, 1'b0, 1'b0);

      // R8 latched: everything clear, boot low, still off
      step(10'b1100010010, 12);
      chk(8, run_aux, run_main, 1'b0, 1'b0);

      // R9 toggle while feedback flag high
      step(10'b1100010110, 6);
      step(10'b1100010100, 6);
      step(10'b1100010110, 6);
      step(10'b1100010010, 8);
      chk(9, run_aux, run_main, 1'b0, 1'b0);

      // R9 toggle while bootstrap not below reset level
      step(10'b1100000010, 6);
      step(10'b1100000000, 6);
      step(10'b1100000010, 6);
      step(10'b1100010010, 8);
      chk(9, run_aux, run_main, 1'b0, 1'b0);

      // R8 release by enable edge; disabled level holds it off (R1)
      step(10'b1100010000, 6);
      chk(1, run_aux, run_main, 1'b0, 1'b0);
      step(10'b1100010010, 6);
      chk(8, run_aux, run_main, 1'b1, 1'b0);
      step(10'b1100100010, 6);
      chk(10, run_aux, run_main, 1'b1, 1'b1);

      // R6 trip again, R8 release by undervoltage toggle
      step(10'b1100011010, 14);
      chk(6, run_aux, run_main, 1'b0, 1'b0);
      step(10'b1100010010, 6);
      chk(8, run_aux, run_main, 1'b0, 1'b0);
      step(10'b1110010010, 6);
      chk(2, run_aux, run_main, 1'b0, 1'b0);
      step(10'b1100010010, 6);
      chk(8, run_aux, run_main, 1'b1, 1'b0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R0: watchdog expired, actual hung, expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule